// File: doc/BRIEF.md
# Nine-Bit Multiprocessor Serial Port

This block is a full-duplex asynchronous serial port for a small controller subsystem. It sends and receives framed characters on two single-wire lines. It has three framed formats: an eight-bit format and two nine-bit formats. The two nine-bit formats differ only in where their bit clock comes from. In the eight-bit format and in one of the nine-bit formats, the bit clock comes from an external timer-overflow tick. In the other nine-bit format it is a fixed division of the system clock.

Software drives the block through a small register bus with three registers: control, data and configuration. A write to the data register launches a character. The most recent accepted character is read back from the same address.

On reception, the ninth bit can filter frames for multi-drop addressing. With filtering on, a nine-bit frame whose ninth bit is clear raises no receive flag and does not update the read buffer. A sticky framing-error flag records any stop bit that was sampled low. It can be viewed in the top bit of the control register through an alias selected in the configuration register. One interrupt line reports the transmit and receive flags.

Top module: `ser9_port`

The transmitter state machine has five states:

| State | Meaning | Next state |
|---|---|---|
| TX_IDLE | Line held high | TX_START when a character is loaded |
| TX_START | Start bit | TX_DATA |
| TX_DATA | Eight data bits | TX_NINTH in a nine-bit format, otherwise TX_STOP |
| TX_NINTH | Ninth bit | TX_STOP |
| TX_STOP | Stop bit | TX_IDLE |

Each transition in the transmitter happens at the end of a bit time of 16 oversample ticks.

The receiver state machine has five states:

| State | Meaning | Next state |
|---|---|---|
| RX_IDLE | Waiting for a low sample while reception is enabled | RX_START on a low sample |
| RX_START | Start bit being checked | RX_IDLE if the majority vote at mid-bit is high (false start); otherwise RX_DATA at the end of the bit |
| RX_DATA | Eight data bits | RX_NINTH in a nine-bit format, otherwise RX_STOP |
| RX_NINTH | Ninth bit | RX_STOP |
| RX_STOP | Stop bit | RX_IDLE at the mid-bit vote |

The frame completes in RX_STOP at the mid-bit vote.

## Requirements

Register addresses on `bus_addr`:
- 0 is the control register.
- 1 is the data register.
- 2 is the configuration register.
- 3 reads as 0.

Control register bit fields:
- Bits [7:6] hold the format: 00 off, 01 eight-bit timer-clocked, 10 nine-bit fixed-rate, 11 nine-bit timer-clocked.
- Bit 5 is the address filter.
- Bit 4 is the receive enable.
- Bit 3 is the transmit ninth bit.
- Bit 2 is the received ninth bit.
- Bit 1 is the transmit-done flag.
- Bit 0 is the receive-done flag.

Configuration register bit fields:
- Bit 0 selects the error alias.
- Bit 1 selects the fast fixed rate.

- R1: After reset, control reads 00h, configuration reads 00h, `ser_out` is 1 and `irq` is 0. `ser_out` is 1 whenever no character is being sent.
- R2: In format 01, a data write sends 0, then the 8 data bits LSB first, then 1. In format 00, a data write sends nothing.
- R3: In formats 10 and 11, the frame carries 0, then 8 data bits LSB first, then the control bit 3 value captured when the character was loaded, then 1.
- R4: Transmit-done (bit 1) rises as the stop bit begins and stays set until software writes it 0. A data write while a character is in flight is ignored.
- R5: In format 01, a received frame puts its byte in the read buffer, its stop bit in bit 2, and sets receive-done (bit 0).
- R6: In formats 10 and 11, the received ninth bit goes to bit 2.
- R7: In formats 10 and 11 with bit 5 set, a frame whose ninth bit is 0 sets no receive-done and leaves the read buffer and bit 2 unchanged.
- R8: In format 01 with bit 5 set, a frame whose stop bit is sampled 0 sets no receive-done.
- R9: A stop bit sampled 0 sets a sticky framing-error flag. A later valid frame leaves it set. While configuration bit 0 is 1, control bit 7 reads this flag, a write of 0 there clears it, and the format is unaffected.
- R10: With bit 4 clear, frames on `ser_in` are not received.
- R11: In format 10, one bit lasts 32 clocks with configuration bit 1 clear, or 16 clocks with it set. In formats 01 and 11, one bit lasts 16 `tmr_tick` pulses.
- R12: Each bit is the majority of three samples around mid-bit, so a one-clock glitch does not corrupt it. A low pulse shorter than half a bit starts no frame.
- R13: `irq` is 1 exactly when transmit-done or receive-done is set.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tmr_tick | input | 1 | Timer overflow pulse, one clock wide |
| ser_in | input | 1 | Serial receive line, idle high |
| ser_out | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Interrupt request |

## Verification

The assertions rely on these conditions about the block's inputs:
- `tmr_tick` is a single-clock pulse.
- Software writes at most one register per cycle.
- The stop-bit flag checks rely on a hardware set taking priority over a software write in the same cycle.
- The receiver assertion assumes the enable gates only the idle state, so a frame already in progress completes.

The stimulus keeps within these conditions:
- The timer tick has a fixed period of three clocks.
- The format is changed only while both lines are idle.
- A stop bit driven low is released after ten sixteenths of a bit. The restart it provokes then meets a high line at mid-bit and is rejected as a false start.

// File: rtl/ser9_pkg.sv
package ser9_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_8T  = 2'b01,
        MODE_9F  = 2'b10,
        MODE_9T  = 2'b11
    } port_mode_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_NINTH,
        TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_NINTH,
        RX_STOP
    } rx_state_t;

endpackage

// File: rtl/ser9_baud.sv
module ser9_baud
    import ser9_pkg::*;
#(
    parameter int SLOW_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  port_mode_t mode,
    input  logic       fast,
    input  logic       tmr_tick,
    output logic       os_tick
);
    localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic [DW-1:0] div_q;
    logic          div_wrap;

    assign div_wrap = (div_q == DW'(SLOW_DIV - 1));

    // Free-running divider for the fixed-rate format.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (div_wrap) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    // Oversample tick: 16 ticks make one bit.
    always_comb begin
        unique case (mode)
            MODE_9F:          os_tick = fast ? 1'b1 : div_wrap;
            MODE_8T, MODE_9T: os_tick = tmr_tick;
            default:          os_tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/ser9_tx.sv
module ser9_tx
    import ser9_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              nine,
    input  logic              bit9,
    output logic              ser_out,
    output logic              busy,
    output logic              done_set
);
    localparam int CW = $clog2(OSR);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_t         state_q, state_d;
    logic [CW-1:0]     tick_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              nine_q, b9_q;
    logic              bit_end;

    assign bit_end = os_tick && (tick_q == CW'(OSR - 1));

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load) state_d = TX_START;
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && bit_q == BW'(DATA_W - 1))
                          state_d = nine_q ? TX_NINTH : TX_STOP;
            TX_NINTH: if (bit_end) state_d = TX_STOP;
            TX_STOP:  if (bit_end) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Bit timing and shift datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            nine_q <= 1'b0;
            b9_q   <= 1'b0;
        end else begin
            if (state_q == TX_IDLE) tick_q <= '0;
            else if (os_tick)       tick_q <= bit_end ? '0 : tick_q + 1'b1;

            if (state_q == TX_IDLE && load) begin
                sh_q   <= load_data;
                nine_q <= nine;
                b9_q   <= bit9;
                bit_q  <= '0;
            end else if (state_q == TX_DATA && bit_end) begin
                sh_q  <= sh_q >> 1;
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            TX_START: ser_out = 1'b0;
            TX_DATA:  ser_out = sh_q[0];
            TX_NINTH: ser_out = b9_q;
            default:  ser_out = 1'b1;
        endcase
        busy     = (state_q != TX_IDLE);
        done_set = (state_d == TX_STOP) && (state_q != TX_STOP);
    end
endmodule

// File: rtl/ser9_rx.sv
module ser9_rx
    import ser9_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              enable,
    input  logic              nine,
    input  logic              ser_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              bit9,
    output logic              stop_ok
);
    localparam int CW    = $clog2(OSR);
    localparam int BW    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int MID_A = OSR / 2 - 1;
    localparam int MID_B = MID_A + 1;
    localparam int MID_C = MID_A + 2;

    rx_state_t         state_q, state_d;
    logic [CW-1:0]     tick_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              s1_q, s2_q, va_q, vb_q, b9_q, nine_q;
    logic              bit_end, mid_a, mid_b, mid_c, maj;

    assign bit_end = os_tick && (tick_q == CW'(OSR - 1));
    assign mid_a   = os_tick && (tick_q == CW'(MID_A));
    assign mid_b   = os_tick && (tick_q == CW'(MID_B));
    assign mid_c   = os_tick && (tick_q == CW'(MID_C));
    assign maj     = (va_q & vb_q) | (va_q & s2_q) | (vb_q & s2_q);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (enable && os_tick && !s2_q) state_d = RX_START;
            RX_START: if (mid_c && maj) state_d = RX_IDLE;
                      else if (bit_end) state_d = RX_DATA;
            RX_DATA:  if (bit_end && bit_q == BW'(DATA_W - 1))
                          state_d = nine_q ? RX_NINTH : RX_STOP;
            RX_NINTH: if (bit_end) state_d = RX_STOP;
            RX_STOP:  if (mid_c) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Synchroniser, sampling and shift datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            va_q   <= 1'b1;
            vb_q   <= 1'b1;
            tick_q <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            b9_q   <= 1'b0;
            nine_q <= 1'b0;
        end else begin
            s1_q <= ser_in;
            s2_q <= s1_q;
            if (mid_a) va_q <= s2_q;
            if (mid_b) vb_q <= s2_q;

            if (state_q == RX_IDLE) begin
                tick_q <= '0;
                bit_q  <= '0;
                nine_q <= nine;
            end else begin
                if (os_tick) tick_q <= bit_end ? '0 : tick_q + 1'b1;
                if (state_q == RX_DATA && bit_end) bit_q <= bit_q + 1'b1;
            end

            if (state_q == RX_DATA && mid_c)  sh_q <= {maj, sh_q[DATA_W-1:1]};
            if (state_q == RX_NINTH && mid_c) b9_q <= maj;
        end
    end

    // Outputs.
    always_comb begin
        busy    = (state_q != RX_IDLE);
        done    = (state_q == RX_STOP) && mid_c;
        data    = sh_q;
        bit9    = b9_q;
        stop_ok = maj;
    end
endmodule

// File: rtl/ser9_port.sv
module ser9_port
    import ser9_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int SLOW_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       tmr_tick,
    input  logic       ser_in,
    output logic       ser_out,
    output logic       irq
);
    localparam int DATA_W = 8;

    port_mode_t        mode_q;
    logic              filt_q, rx_en_q, tx9_q, rx9_q, txf_q, rxf_q;
    logic              ferr_q, alias_q, fast_q;
    logic [DATA_W-1:0] rbuf_q;

    logic              wr_ctl, wr_dat, wr_cfg;
    logic              os_tick, tx_busy, tx_set, tx_load;
    logic              rx_on, rx_busy, rx_done, rx_b9, rx_stop_ok, rx_accept;
    logic [DATA_W-1:0] rx_data;

    assign wr_ctl  = bus_wr && (bus_addr == 2'd0);
    assign wr_dat  = bus_wr && (bus_addr == 2'd1);
    assign wr_cfg  = bus_wr && (bus_addr == 2'd2);
    assign tx_load = wr_dat && (mode_q != MODE_OFF) && !tx_busy;
    assign rx_on   = rx_en_q && (mode_q != MODE_OFF);

    // Address filter: the ninth bit in nine-bit formats, the stop bit otherwise.
    assign rx_accept = !filt_q || (mode_q[1] ? rx_b9 : rx_stop_ok);

    ser9_baud #(.SLOW_DIV(SLOW_DIV)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .fast     (fast_q),
        .tmr_tick (tmr_tick),
        .os_tick  (os_tick)
    );

    ser9_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .load      (tx_load),
        .load_data (bus_wdata),
        .nine      (mode_q[1]),
        .bit9      (tx9_q),
        .ser_out   (ser_out),
        .busy      (tx_busy),
        .done_set  (tx_set)
    );

    ser9_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .enable  (rx_on),
        .nine    (mode_q[1]),
        .ser_in  (ser_in),
        .busy    (rx_busy),
        .done    (rx_done),
        .data    (rx_data),
        .bit9    (rx_b9),
        .stop_ok (rx_stop_ok)
    );

    // Register file; hardware events come last and win over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_OFF;
            filt_q  <= 1'b0;
            rx_en_q <= 1'b0;
            tx9_q   <= 1'b0;
            rx9_q   <= 1'b0;
            txf_q   <= 1'b0;
            rxf_q   <= 1'b0;
            ferr_q  <= 1'b0;
            alias_q <= 1'b0;
            fast_q  <= 1'b0;
            rbuf_q  <= '0;
        end else begin
            if (wr_ctl) begin
                if (alias_q) begin
                    if (!bus_wdata[7]) ferr_q <= 1'b0;
                    mode_q <= port_mode_t'({mode_q[1], bus_wdata[6]});
                end else begin
                    mode_q <= port_mode_t'(bus_wdata[7:6]);
                end
                filt_q  <= bus_wdata[5];
                rx_en_q <= bus_wdata[4];
                tx9_q   <= bus_wdata[3];
                rx9_q   <= bus_wdata[2];
                txf_q   <= bus_wdata[1];
                rxf_q   <= bus_wdata[0];
            end
            if (wr_cfg) begin
                alias_q <= bus_wdata[0];
                fast_q  <= bus_wdata[1];
            end
            if (tx_set) txf_q <= 1'b1;
            if (rx_done) begin
                if (!rx_stop_ok) ferr_q <= 1'b1;
                if (rx_accept) begin
                    rxf_q  <= 1'b1;
                    rbuf_q <= rx_data;
                    rx9_q  <= mode_q[1] ? rx_b9 : rx_stop_ok;
                end
            end
        end
    end

    // Read mux and interrupt.
    always_comb begin
        unique case (bus_addr)
            2'd0:    bus_rdata = {alias_q ? ferr_q : mode_q[1], mode_q[0], filt_q,
                                  rx_en_q, tx9_q, rx9_q, txf_q, rxf_q};
            2'd1:    bus_rdata = rbuf_q;
            2'd2:    bus_rdata = {6'd0, fast_q, alias_q};
            default: bus_rdata = 8'd0;
        endcase
        irq = txf_q | rxf_q;
    end
endmodule

// File: rtl/ser9_port_chk.sv
module ser9_port_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_out,
    input logic tx_busy,
    input logic tx_set,
    input logic txf,
    input logic rxf,
    input logic irq,
    input logic ferr,
    input logic wr_ctl,
    input logic rx_on,
    input logic rx_busy
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> ser_out);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !ser_out);

    assert_done_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set |=> txf);

    assert_ferr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ferr && !wr_ctl |=> ferr);

    assert_rx_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_on && !rx_busy |=> !rx_busy);

    assert_irq_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (txf || rxf) |-> irq);

    assert_irq_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!txf && !rxf) |-> !irq);
endmodule

bind ser9_port ser9_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_out (ser_out),
    .tx_busy (tx_busy),
    .tx_set  (tx_set),
    .txf     (txf_q),
    .rxf     (rxf_q),
    .irq     (irq),
    .ferr    (ferr_q),
    .wr_ctl  (wr_ctl),
    .rx_on   (rx_on),
    .rx_busy (rx_busy)
);

// File: tb/ser9_port_tb.sv
`timescale 1ns/1ps
module ser9_port_tb;
    localparam int TMR_DIV = 3;
    localparam int BL_T    = 16 * TMR_DIV;
    localparam int BL_FAST = 16;
    localparam int WD      = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       tmr_tick = 1'b0;
    logic       ser_in = 1'b1;
    logic       ser_out, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] exp_buf = 8'd0;

    always #2.5 clk = ~clk;

    ser9_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_tick(tmr_tick),
        .ser_in(ser_in), .ser_out(ser_out), .irq(irq)
    );

    initial begin
        forever begin
            repeat (TMR_DIV - 1) @(negedge clk);
            tmr_tick = 1'b1;
            @(negedge clk);
            tmr_tick = 1'b0;
        end
    end

    function automatic bit exp_accept(input bit nine, input bit filt,
                                      input bit b9, input bit stp);
        return !filt || (nine ? b9 : stp);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = 2'd0;
    endtask

    task automatic wait_fall(input int limit, output bit ok);
        int t = 0;
        while (ser_out !== 1'b0 && t < limit) begin
            @(negedge clk);
            t++;
        end
        ok = (t < limit);
    endtask

    task automatic recv_frame(input int bl, input bit nine, output logic [7:0] d,
                              output bit b9, output bit stp, output bit ok);
        logic [7:0] c;
        d = 8'd0; b9 = 1'b0; stp = 1'b0;
        wait_fall(bl * 40, ok);
        if (!ok) return;
        repeat (bl / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (bl) @(negedge clk);
            d[i] = ser_out;
        end
        if (nine) begin
            repeat (bl) @(negedge clk);
            b9 = ser_out;
        end
        peek(2'd0, c);
        chk("R4 done flag before stop bit", int'(c[1]), 0);
        repeat (bl) @(negedge clk);
        stp = ser_out;
        peek(2'd0, c);
        chk("R4 done flag at stop bit", int'(c[1]), 1);
    endtask

    task automatic send_frame(input int bl, input logic [7:0] d, input bit nine,
                              input bit b9, input bit stp, input int gl_bit);
        logic [10:0] fr;
        int n;
        n  = nine ? 11 : 10;
        fr = nine ? {stp, b9, d, 1'b0} : {1'b0, stp, d, 1'b0};
        for (int i = 0; i < n; i++) begin
            ser_in = fr[i];
            if (i == gl_bit) begin
                repeat (bl / 2) @(negedge clk);
                ser_in = ~fr[i];
                @(negedge clk);
                ser_in = fr[i];
                repeat (bl - bl / 2 - 1) @(negedge clk);
            end else if (i == n - 1 && !fr[i]) begin
                repeat (bl * 10 / 16) @(negedge clk);
            end else begin
                repeat (bl) @(negedge clk);
            end
        end
        ser_in = 1'b1;
        repeat (bl) @(negedge clk);
    endtask

    task automatic measure_low(output int cnt);
        bit ok;
        cnt = 0;
        wait_fall(4000, ok);
        while (ser_out === 1'b0 && cnt < 4000) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    task automatic rx_case(input string tag, input int bl, input bit nine,
                           input bit filt, input logic [7:0] d, input bit b9,
                           input bit stp, input bit en, input int gl_bit);
        logic [7:0] c, b;
        bit acc;
        acc = en && exp_accept(nine, filt, b9, stp);
        send_frame(bl, d, nine, b9, stp, gl_bit);
        if (acc) exp_buf = d;
        peek(2'd0, c);
        peek(2'd1, b);
        chk({tag, " receive-done"}, int'(c[0]), int'(acc));
        chk({tag, " read buffer"}, int'(b), int'(exp_buf));
        if (acc) chk({tag, " ninth/stop bit"}, int'(c[2]), int'(nine ? b9 : stp));
    endtask

    initial begin
        logic [7:0] v, d;
        bit b9, stp, ok;
        int m;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, v); chk("R1 control reset", int'(v), 8'h00);
        peek(2'd2, v); chk("R1 config reset", int'(v), 8'h00);
        chk("R1 ser_out idle", int'(ser_out), 1);
        chk("R1 irq reset", int'(irq), 0);

        // R2 format 00 sends nothing
        bus_write(2'd1, 8'h55);
        m = 0;
        repeat (200) begin @(negedge clk); if (ser_out === 1'b0) m++; end
        chk("R2 format off sends nothing", m, 0);

        // R2/R4 format 01 frame, with a write while busy
        bus_write(2'd0, 8'h40);
        bus_write(2'd1, 8'hA5);
        bus_write(2'd1, 8'h3C);
        recv_frame(BL_T, 1'b0, d, b9, stp, ok);
        chk("R2 frame seen", int'(ok), 1);
        chk("R2 data LSB first", int'(d), 8'hA5);
        chk("R2 stop bit", int'(stp), 1);
        m = 0;
        repeat (BL_T * 3) begin @(negedge clk); if (ser_out === 1'b0) m++; end
        chk("R4 busy write ignored", m, 0);
        chk("R13 irq with done flag", int'(irq), 1);
        bus_write(2'd0, 8'h40);
        @(negedge clk);
        peek(2'd0, v); chk("R4 done flag cleared by write", int'(v[1]), 0);
        chk("R13 irq cleared", int'(irq), 0);

        // R3 format 11 ninth bit 1; R11 timer bit length
        bus_write(2'd0, 8'hC8);
        bus_write(2'd1, 8'h3C);
        recv_frame(BL_T, 1'b1, d, b9, stp, ok);
        chk("R3 data", int'(d), 8'h3C);
        chk("R3 ninth bit", int'(b9), 1);
        chk("R3 stop bit", int'(stp), 1);
        repeat (BL_T) @(negedge clk);
        bus_write(2'd0, 8'hC0);
        bus_write(2'd1, 8'h01);
        measure_low(m);
        chk("R11 timer-clocked bit length", int'(m >= 45 && m <= 49), 1);
        repeat (BL_T * 12) @(negedge clk);

        // R11 fixed rate, slow and fast
        bus_write(2'd0, 8'h80);
        bus_write(2'd1, 8'h01);
        measure_low(m);
        chk("R11 fixed slow bit length", int'(m >= 30 && m <= 33), 1);
        repeat (32 * 12) @(negedge clk);
        bus_write(2'd2, 8'h02);
        bus_write(2'd0, 8'h80);
        bus_write(2'd1, 8'h01);
        measure_low(m);
        chk("R11 fixed fast bit length", int'(m >= 15 && m <= 17), 1);
        repeat (16 * 12) @(negedge clk);

        // R3 format 10 ninth bit 0
        bus_write(2'd0, 8'h80);
        bus_write(2'd1, 8'hE7);
        recv_frame(BL_FAST, 1'b1, d, b9, stp, ok);
        chk("R3 fixed data", int'(d), 8'hE7);
        chk("R3 fixed ninth bit", int'(b9), 0);
        repeat (BL_FAST * 2) @(negedge clk);

        // R5 format 01 receive
        bus_write(2'd0, 8'h50);
        rx_case("R5", BL_T, 1'b0, 1'b0, 8'h96, 1'b0, 1'b1, 1'b1, -1);

        // R8 filtered bad stop, R9 error flag set
        bus_write(2'd0, 8'h70);
        rx_case("R8", BL_T, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b1, -1);
        bus_write(2'd2, 8'h03);
        peek(2'd0, v); chk("R9 error visible in alias", int'(v[7]), 1);
        bus_write(2'd0, 8'hD0);
        rx_case("R9 valid frame after error", BL_T, 1'b0, 1'b0, 8'h33, 1'b0, 1'b1, 1'b1, -1);
        peek(2'd0, v); chk("R9 error sticky", int'(v[7]), 1);
        chk("R9 format kept under alias", int'(v[6]), 1);
        bus_write(2'd0, 8'h50);
        peek(2'd0, v); chk("R9 error cleared by write 0", int'(v[7]), 0);
        bus_write(2'd2, 8'h02);
        peek(2'd0, v); chk("R9 format unchanged by alias writes", int'(v[7:6]), 2'b01);

        // R7/R6 address filter in nine-bit formats
        bus_write(2'd0, 8'hF0);
        rx_case("R7 filtered ninth 0", BL_T, 1'b1, 1'b1, 8'h11, 1'b0, 1'b1, 1'b1, -1);
        rx_case("R6 filtered ninth 1", BL_T, 1'b1, 1'b1, 8'h22, 1'b1, 1'b1, 1'b1, -1);
        bus_write(2'd0, 8'h94);
        rx_case("R6 unfiltered ninth 0", BL_FAST, 1'b1, 1'b0, 8'h44, 1'b0, 1'b1, 1'b1, -1);

        // R10 receiver disabled
        bus_write(2'd0, 8'h80);
        rx_case("R10 disabled", BL_FAST, 1'b1, 1'b0, 8'h77, 1'b1, 1'b1, 1'b0, -1);

        // R12 glitch and false start
        bus_write(2'd0, 8'h90);
        rx_case("R12 glitch in data", BL_FAST, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b1, 1'b1, 3);
        bus_write(2'd0, 8'h90);
        ser_in = 1'b0;
        repeat (5) @(negedge clk);
        ser_in = 1'b1;
        repeat (BL_FAST * 14) @(negedge clk);
        peek(2'd0, v); chk("R12 false start ignored", int'(v[0]), 0);

        // Random receive frames in nine-bit formats
        for (int it = 0; it < 16; it++) begin
            bit f, r9, t3;
            logic [7:0] rd;
            f = 1'($urandom); r9 = 1'($urandom); t3 = 1'($urandom);
            rd = 8'($urandom);
            bus_write(2'd0, {1'b1, t3, f, 1'b1, 4'b0000});
            rx_case(f ? "R7 random" : "R6 random", t3 ? BL_T : BL_FAST, 1'b1, f,
                    rd, r9, 1'b1, 1'b1, -1);
        end

        // Random transmit frames in nine-bit formats
        for (int it = 0; it < 6; it++) begin
            bit r9, t3;
            logic [7:0] td;
            r9 = 1'($urandom); t3 = 1'($urandom); td = 8'($urandom);
            bus_write(2'd0, {1'b1, t3, 2'b00, r9, 3'b000});
            bus_write(2'd1, td);
            recv_frame(t3 ? BL_T : BL_FAST, 1'b1, d, b9, stp, ok);
            chk("R3 random data", int'(d), int'(td));
            chk("R3 random ninth", int'(b9), int'(r9));
            repeat ((t3 ? BL_T : BL_FAST) * 2) @(negedge clk);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule